// File: doc/BRIEF.md
# Transmit Frame Encapsulation Unit

This block turns an outgoing packet, supplied as a stream of 32-bit words, into the byte stream that a line-side transmitter sends. Each word carries active-low byte enables and a flag that marks the final word of the packet. The block puts a synchronisation preamble and a start delimiter in front of the frame and appends a CRC-32 frame check sequence. It can also stretch short frames to the minimum legal size with zero bytes.

The preamble, the CRC and the padding can each be switched off. The CRC can be dropped for all frames through a global configuration input. It can also be dropped for a single frame through a per-word input: if that input is high on any word of the packet, the packet goes out with no FCS.

Both edges use a valid/ready handshake. A packet starts when a word is offered while the block is idle. Further words are taken while the frame is being built. No word of the next packet is taken until the last byte of the current frame has been handed over.

Top module: `tx_encap`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are both low.
- R2: Every frame begins with seven bytes 0x55 and then one byte 0xD5. When `cfg_nopre` is high at the start of the packet, the frame begins directly with the first data byte.
- R3: Byte lane i of `in_data` is bits 8i+7..8i and is valid when `in_be_n[i]` is 0. The valid lanes of a word are sent in ascending lane order, and disabled lanes are skipped. A word that is not the last word and has no valid lane adds nothing to the frame. The last word always has at least one valid lane.
- R4: Unless it is suppressed, four FCS bytes follow the body, least significant byte first. The FCS is the inverted CRC-32 with polynomial 0x04C11DB7, bit-reflected, with the register preset to all ones. It covers every data byte and every pad byte, and none of the preamble.
- R5: If `in_nocrc` is high on any word accepted for a packet, that packet carries no FCS. The following packets are not affected.
- R6: While `cfg_nocrc_all` is high, no frame carries an FCS.
- R7: When `cfg_autopad` is high at the start of the packet and the body is shorter than 60 bytes, 0x00 bytes are appended until the body is 60 bytes long. A body of 60 bytes or more, or any body with autopad low, is not padded.
- R8: `out_last` is high only on the final byte of a frame. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R9: `in_ready` stays low from the handover of a frame's last byte until a new packet has started. A word offered while the block is idle starts the packet and is not consumed in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted this cycle when both are high |
| in_data | input | 32 | Packet word, lane 0 in the low byte |
| in_be_n | input | 4 | Active-low byte enables, one per lane |
| in_eof | input | 1 | Marks the last word of the packet |
| in_nocrc | input | 1 | Per-packet FCS suppression, sampled on each accepted word |
| cfg_nopre | input | 1 | Omit the preamble and delimiter |
| cfg_autopad | input | 1 | Pad short bodies to 60 bytes |
| cfg_nocrc_all | input | 1 | Omit the FCS on all frames |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Line side takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The bench targets body lengths just below, at and above the 60-byte pad limit. A design with an off-by-one error in its pad count would send 59 or 61 body bytes, or would pad a frame that needs no padding. Sparse byte enables and an all-disabled middle word are used to expose lane-order or lane-skip errors, which show up as reordered, duplicated or stray 0xA5 bytes in the output. The per-packet CRC flag is raised on a single middle word and then followed by a normal packet: a design that samples the flag only on the first or last word would append an FCS, and one that fails to clear the flag would drop the next packet's FCS. Random back-pressure on the output checks that a stalled byte holds and that the CRC is not advanced twice.

// File: rtl/tx_encap_pkg.sv
package tx_encap_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_DATA,
    PH_PAD,
    PH_FCS
  } phase_t;

  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  // One byte through the reflected CRC-32 register, bit 0 of the byte first.
  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_REFL;
    end
    return r;
  endfunction

endpackage

// File: rtl/tx_encap_unpack.sv
module tx_encap_unpack #(
  parameter int LANES = 4,
  localparam int DW   = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_en,
  input  logic             pkt_start,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [LANES-1:0] in_be_n,
  input  logic             in_eof,
  input  logic             in_nocrc,
  output logic             in_ready,
  output logic             word_eof,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_eof,
  input  logic             byte_pop,
  output logic             pkt_nocrc
);

  logic [DW-1:0]    wbuf;
  logic [LANES-1:0] wmask;
  logic [LANES-1:0] low;
  logic [LANES-1:0] rest;
  logic             weof;
  logic             full;
  logic             word_take;

  assign in_ready   = accept_en && !full;
  assign word_take  = in_valid && in_ready;
  assign word_eof   = word_take && in_eof;
  assign byte_valid = full;

  // lowest pending lane as a one-hot mask
  assign low  = wmask & (~wmask + LANES'(1));
  assign rest = wmask & ~low;
  assign byte_eof = weof && (rest == '0);

  always_comb begin
    byte_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (low[i]) byte_data = byte_data | wbuf[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbuf      <= '0;
      wmask     <= '0;
      weof      <= 1'b0;
      full      <= 1'b0;
      pkt_nocrc <= 1'b0;
    end else begin
      if (word_take) begin
        if (|(~in_be_n)) begin
          wbuf  <= in_data;
          wmask <= ~in_be_n;
          weof  <= in_eof;
          full  <= 1'b1;
        end
      end else if (byte_pop) begin
        wmask <= rest;
        if (rest == '0) full <= 1'b0;
      end
      if (pkt_start)                  pkt_nocrc <= 1'b0;
      else if (word_take && in_nocrc) pkt_nocrc <= 1'b1;
    end
  end

  // R3: a byte is only taken from a held word
  assert_pop_from_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_pop |-> byte_valid);

  // R3: a held word always offers a lane
  assert_held_has_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $countones(low) == 1);

endmodule

// File: rtl/tx_encap_crc.sv
module tx_encap_crc
  import tx_encap_pkg::*;
#(
  parameter int FCS_BYTES = 4,
  localparam int FSW      = $clog2(FCS_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init,
  input  logic           upd,
  input  logic [7:0]     din,
  input  logic [FSW-1:0] sel,
  output logic [7:0]     fcs_byte
);

  logic [31:0] crc;
  logic [31:0] fcs;

  assign fcs = ~crc;

  always_comb begin
    fcs_byte = '0;
    for (int i = 0; i < FCS_BYTES; i++) begin
      if (sel == FSW'(i)) fcs_byte = fcs[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (init) crc <= CRC_SEED;
    else if (upd)  crc <= crc32_step(crc, din);
  end

  // R4: the register is never preset and advanced in one cycle
  assert_seed_excl_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(init && upd));

  // R4: the register holds while the FCS is being read out
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(upd) && !$past(init) |-> $stable(crc));

endmodule

// File: rtl/tx_encap_seq.sv
module tx_encap_seq
  import tx_encap_pkg::*;
#(
  parameter int PRE_LEN   = 7,
  parameter int MIN_BODY  = 60,
  parameter int FCS_BYTES = 4,
  localparam int CMAX     = (PRE_LEN > FCS_BYTES) ? PRE_LEN : FCS_BYTES,
  localparam int CW       = $clog2(CMAX + 1),
  localparam int BW       = $clog2(MIN_BODY + 1),
  localparam int FSW      = $clog2(FCS_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           cfg_nopre,
  input  logic           cfg_autopad,
  input  logic           cfg_nocrc_all,
  input  logic           pkt_nocrc,
  input  logic           word_eof,
  input  logic           byte_valid,
  input  logic [7:0]     byte_data,
  input  logic           byte_eof,
  output logic           byte_pop,
  input  logic [7:0]     fcs_byte,
  output logic [FSW-1:0] fcs_sel,
  output logic           crc_init,
  output logic           crc_upd,
  output logic [7:0]     crc_din,
  output logic           pkt_start,
  output logic           accept_en,
  output logic           out_valid,
  output logic [7:0]     out_data,
  output logic           out_last,
  input  logic           out_ready
);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [BW-1:0] body;
  logic [BW-1:0] body_next;
  logic          pkt_open;
  logic          pad_en;
  logic          crc_on;
  logic          pad_more;
  logic          fcs_end;
  logic          fire;

  assign pkt_start = (phase == PH_IDLE) && in_valid;
  assign accept_en = pkt_open;
  assign crc_on    = !(cfg_nocrc_all || pkt_nocrc);
  assign body_next = (body >= BW'(MIN_BODY)) ? body : body + BW'(1);
  assign pad_more  = pad_en && (body_next < BW'(MIN_BODY));
  assign fcs_end   = (cnt == CW'(FCS_BYTES - 1));
  assign fire      = out_valid && out_ready;
  assign byte_pop  = (phase == PH_DATA) && fire;
  assign crc_init  = pkt_start;
  assign crc_upd   = fire && ((phase == PH_DATA) || (phase == PH_PAD));
  assign crc_din   = out_data;
  assign fcs_sel   = cnt[FSW-1:0];

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    unique case (phase)
      PH_PRE: begin
        out_valid = 1'b1;
        out_data  = (cnt == CW'(PRE_LEN)) ? SFD_BYTE : PRE_BYTE;
      end
      PH_DATA: begin
        out_valid = byte_valid;
        out_data  = byte_data;
        out_last  = byte_eof && !pad_more && !crc_on;
      end
      PH_PAD: begin
        out_valid = 1'b1;
        out_last  = !pad_more && !crc_on;
      end
      PH_FCS: begin
        out_valid = 1'b1;
        out_data  = fcs_byte;
        out_last  = fcs_end;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      body     <= '0;
      pkt_open <= 1'b0;
      pad_en   <= 1'b0;
    end else begin
      if (word_eof) pkt_open <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (pkt_start) begin
            pkt_open <= 1'b1;
            pad_en   <= cfg_autopad;
            body     <= '0;
            cnt      <= '0;
            phase    <= cfg_nopre ? PH_DATA : PH_PRE;
          end
        end
        PH_PRE: begin
          if (fire) begin
            if (cnt == CW'(PRE_LEN)) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        PH_DATA: begin
          if (fire) begin
            body <= body_next;
            if (byte_eof) begin
              cnt <= '0;
              if (pad_more)    phase <= PH_PAD;
              else if (crc_on) phase <= PH_FCS;
              else             phase <= PH_IDLE;
            end
          end
        end
        PH_PAD: begin
          if (fire) begin
            body <= body_next;
            if (!pad_more) phase <= crc_on ? PH_FCS : PH_IDLE;
          end
        end
        PH_FCS: begin
          if (fire) begin
            if (fcs_end) phase <= PH_IDLE;
            else         cnt   <= cnt + CW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8: a stalled byte holds
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R9: input stays closed once the frame has been handed over
  assert_closed_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_last |=> !accept_en);

  // R7: a padded frame reaches the minimum body before its FCS
  assert_pad_before_fcs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FCS) && pad_en |-> body >= BW'(MIN_BODY));

  // R2: the data phase follows the delimiter
  assert_pre_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_PRE) && (phase == PH_DATA) |-> $past(cnt) == CW'(PRE_LEN));

  // R5, R6: no FCS is read out while suppression is active
  assert_fcs_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FCS) |-> crc_on);

endmodule

// File: rtl/tx_encap.sv
module tx_encap #(
  parameter int LANES     = 4,
  parameter int PRE_LEN   = 7,
  parameter int MIN_FRAME = 64,
  localparam int FCS_BYTES = 4,
  localparam int MIN_BODY  = MIN_FRAME - FCS_BYTES,
  localparam int DW        = 8 * LANES,
  localparam int FSW       = $clog2(FCS_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic [LANES-1:0] in_be_n,
  input  logic             in_eof,
  input  logic             in_nocrc,
  input  logic             cfg_nopre,
  input  logic             cfg_autopad,
  input  logic             cfg_nocrc_all,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);

  logic           accept_en;
  logic           pkt_start;
  logic           word_eof;
  logic           byte_valid;
  logic [7:0]     byte_data;
  logic           byte_eof;
  logic           byte_pop;
  logic           pkt_nocrc;
  logic           crc_init;
  logic           crc_upd;
  logic [7:0]     crc_din;
  logic [FSW-1:0] fcs_sel;
  logic [7:0]     fcs_byte;

  tx_encap_unpack #(.LANES(LANES)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_en  (accept_en),
    .pkt_start  (pkt_start),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_be_n    (in_be_n),
    .in_eof     (in_eof),
    .in_nocrc   (in_nocrc),
    .in_ready   (in_ready),
    .word_eof   (word_eof),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_eof   (byte_eof),
    .byte_pop   (byte_pop),
    .pkt_nocrc  (pkt_nocrc)
  );

  tx_encap_crc #(.FCS_BYTES(FCS_BYTES)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (crc_init),
    .upd      (crc_upd),
    .din      (crc_din),
    .sel      (fcs_sel),
    .fcs_byte (fcs_byte)
  );

  tx_encap_seq #(
    .PRE_LEN   (PRE_LEN),
    .MIN_BODY  (MIN_BODY),
    .FCS_BYTES (FCS_BYTES)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .cfg_nopre     (cfg_nopre),
    .cfg_autopad   (cfg_autopad),
    .cfg_nocrc_all (cfg_nocrc_all),
    .pkt_nocrc     (pkt_nocrc),
    .word_eof      (word_eof),
    .byte_valid    (byte_valid),
    .byte_data     (byte_data),
    .byte_eof      (byte_eof),
    .byte_pop      (byte_pop),
    .fcs_byte      (fcs_byte),
    .fcs_sel       (fcs_sel),
    .crc_init      (crc_init),
    .crc_upd       (crc_upd),
    .crc_din       (crc_din),
    .pkt_start     (pkt_start),
    .accept_en     (accept_en),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_last      (out_last),
    .out_ready     (out_ready)
  );

endmodule

// File: tb/sim_tx_encap.sv
`timescale 1ns/1ps
module sim_tx_encap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [3:0]  in_be_n = 4'hF;
  logic        in_eof = 1'b0;
  logic        in_nocrc = 1'b0;
  logic        cfg_nopre = 1'b0;
  logic        cfg_autopad = 1'b0;
  logic        cfg_nocrc_all = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;

  always #2.5 clk = ~clk;

  tx_encap u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_be_n(in_be_n), .in_eof(in_eof), .in_nocrc(in_nocrc),
    .cfg_nopre(cfg_nopre), .cfg_autopad(cfg_autopad), .cfg_nocrc_all(cfg_nocrc_all),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int          n_checks = 0;
  int          n_fail = 0;
  logic [8:0]  exp_q[$];
  string       tag_q[$];
  string       end_tag = "R4";
  bit          full_ready = 1'b1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // plain MSB-first CRC, then bit-reversed and inverted
  function automatic logic [31:0] ref_fcs(logic [7:0] q[$]);
    logic [31:0] c, r;
    logic        fb;
    c = 32'hFFFF_FFFF;
    foreach (q[k]) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ q[k][i];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    return ~r;
  endfunction

  task automatic push(logic [7:0] d, bit last, string tag);
    exp_q.push_back({last, d});
    tag_q.push_back(tag);
  endtask

  task automatic put_word(logic [31:0] d, logic [3:0] be, bit eof, bit noc);
    in_valid = 1'b1; in_data = d; in_be_n = be; in_eof = eof; in_nocrc = noc;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0; in_nocrc = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_frame(int n, int seed, bit nopre, bit pad, bit noc_all,
                            int noc_word, bit sparse, bit empty_w, bit rdy_full);
    logic [7:0]  body[$];
    logic [31:0] fcs;
    logic [31:0] d;
    logic [3:0]  be;
    bit          crc_en;
    int          idx, w, total, lane;
    wait (exp_q.size() == 0);
    repeat (3) @(posedge clk);
    #1;
    cfg_nopre = nopre; cfg_autopad = pad; cfg_nocrc_all = noc_all;
    full_ready = rdy_full;
    for (int i = 0; i < n; i++) body.push_back(8'((seed * 37 + i * 13 + 1) & 8'hFF));
    crc_en = !noc_all && (noc_word < 0);
    end_tag = noc_all ? "R6" : (noc_word >= 0 ? "R5" : "R4");
    if (!nopre) begin
      for (int i = 0; i < 7; i++) push(8'h55, 1'b0, "R2");
      push(8'hD5, 1'b0, "R2");
    end
    total = body.size();
    for (int i = 0; i < n; i++)
      push(body[i], (i == n - 1) && !crc_en && !(pad && n < 60), "R3");
    if (pad) begin
      while (body.size() < 60) begin
        body.push_back(8'h00);
        push(8'h00, (body.size() == 60) && !crc_en, "R7");
      end
    end
    if (crc_en) begin
      fcs = ref_fcs(body);
      for (int i = 0; i < 4; i++) push(fcs[8*i +: 8], i == 3, "R4");
    end
    if (total == 0) return;
    idx = 0; w = 0;
    while (idx < n) begin
      d = 32'hA5A5_A5A5; be = 4'hF;
      for (int j = 0; j < (sparse ? 2 : 4); j++) begin
        if (idx < n) begin
          lane = sparse ? (2 * j + 1) : j;
          d[8*lane +: 8] = body[idx];
          be[lane] = 1'b0;
          idx++;
        end
      end
      put_word(d, be, idx >= n, w == noc_word);
      if (empty_w && w == 0) put_word(32'h5A5A_5A5A, 4'hF, 1'b0, 1'b0);
      w++;
    end
  endtask

  // output back-pressure
  initial begin
    logic [15:0] lfsr = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = full_ready | lfsr[0] | lfsr[3];
    end
  end

  // scoreboard monitor
  initial begin
    logic [8:0] e;
    string      t;
    bit         was_stall = 1'b0;
    bit         was_last = 1'b0;
    logic [8:0] held = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (was_last)
          check(in_ready == 1'b0, "R9", "in_ready after last byte", in_ready, 0);
        if (was_stall)
          check(out_valid && ({out_last, out_data} == held), "R8", "stalled byte held",
                {out_valid, out_last, out_data}, {1'b1, held});
        was_last = 1'b0;
        was_stall = out_valid && !out_ready;
        held = {out_last, out_data};
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, end_tag, "unexpected byte", {out_last, out_data}, 0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data == e[7:0], t, "byte value", out_data, e[7:0]);
            check(out_last == e[8], "R8", "last flag", out_last, e[8]);
          end
          was_last = out_last;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
    @(posedge clk); #1;

    send_frame(64, 1, 0, 1, 0, -1, 0, 0, 1);  // R4 long frame, no pad needed
    send_frame(10, 2, 0, 1, 0, -1, 0, 0, 0);  // R7 short frame padded
    send_frame(10, 3, 0, 0, 0, -1, 0, 0, 0);  // R7 autopad off
    send_frame(59, 4, 0, 1, 0, -1, 0, 0, 0);  // R7 one pad byte
    send_frame(60, 5, 0, 1, 0, -1, 0, 0, 0);  // R7 exact limit
    send_frame(61, 6, 0, 1, 0, -1, 0, 0, 1);  // R7 above limit
    send_frame(20, 7, 1, 1, 0, -1, 0, 0, 0);  // R2 no preamble
    send_frame(24, 8, 0, 0, 0, 2, 0, 0, 0);   // R5 flag on a middle word
    send_frame(12, 9, 0, 0, 0, -1, 0, 0, 0);  // R5 next packet keeps FCS
    send_frame(16, 10, 0, 0, 1, -1, 0, 0, 0); // R6 global suppression
    send_frame(8, 11, 0, 1, 1, -1, 0, 0, 1);  // R6 with padding
    send_frame(13, 12, 0, 1, 0, -1, 1, 1, 0); // R3 sparse lanes, empty word
    send_frame(5, 13, 1, 0, 0, -1, 0, 0, 1);  // R3 partial last word
    send_frame(7, 14, 0, 0, 0, 0, 1, 0, 0);   // R5 flag on first word

    wait (exp_q.size() == 0);
    repeat (30) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "idle after final frame", out_valid, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule